// File: doc/BRIEF.md
# Windowed Register Access Translator

This block lets a small external register aperture reach a much larger internal register space. The aperture is cut into equal slices, one for each window. Each window has a configuration entry with two words. The first is a base offset counted in dwords. The second is a pretend word that can make the window's internal accesses carry the identity of another function or port. Software moves a window at run time by rewriting its base offset, then reaches registers near that base through the window's slice.

An accepted aperture access is translated into an internal byte address, which is four times the window's base plus the byte offset inside the slice. The access is then forwarded as one internal request with a ready/valid handshake. That request carries the function id and port chosen by the window's pretend word. The block handles one access at a time. A window whose base still holds the invalid all-ones value does not forward the access: it answers at once with an error flag.

Top module: `win_xlat`

## Requirements
- R1: After reset `ap_ready` is 1 and `int_valid` and `ap_resp_valid` are 0. Every base offset is all-ones and every pretend word is zero, so any aperture access made right after reset takes the error path of R5.
- R2: The window index is `ap_addr[AP_AW-1:SLICE_W]` and the slice offset is `ap_addr[SLICE_W-1:0]`, with SLICE_W = log2(WIN_BYTES). The internal byte address is `base*4 + slice offset`, computed modulo 2^32.
- R3: An aperture write is forwarded with `int_write`=1 and the aperture write data. Its response returns `ap_rdata`=0 with `ap_err`=0.
- R4: For a forwarded read, the `int_rdata` present at the edge where `int_valid` and `int_ready` are both high is returned on `ap_rdata`. It appears with a one-cycle `ap_resp_valid` pulse in the cycle after that edge, and `ap_err` is 0.
- R5: An access to a window whose base equals 32'hFFFFFFFF is not forwarded. In the cycle after acceptance the block responds with `ap_err`=1, and `ap_rdata` is 32'hDEADBEEF for a read and 0 for a write.
- R6: A window whose pretend word is zero issues its internal accesses with `int_fid`=OWN_FID and `int_port`=OWN_PORT.
- R7: The port field is pretend word bits [1:0], use-port is bit 2 and pretend-port is bit 3. `int_port` takes bits [1:0] only when bits 2 and 3 are both set; otherwise it is OWN_PORT.
- R8: Is-concrete is bit 4 and pretend-function is bit 5. When both are set, the function id comes from pretend word bits [31:16]. In that field, bit 15 is VF-valid: when it is set the whole 16-bit field is used, and when it is clear only the PF id in field bits [3:0] is used, zero-extended. Otherwise `int_fid` is OWN_FID.
- R9: Writing a function pretend word with use-port clear returns the window to OWN_PORT, even when the previous pretend word selected another port.
- R10: `cfg_sel[0]` selects the word (0 = base offset, 1 = pretend word) and `cfg_sel[WIN_IW:1]` selects the window. A configuration write made on the same edge as an aperture acceptance is not seen by that access. It is seen by the next access.
- R11: `ap_ready` stays low from the acceptance of a forwarded access until its internal grant. While `int_ready` is low, `int_valid` and the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | WIN_IW+1 | Window index and word select |
| cfg_wdata | input | 32 | Configuration write data |
| ap_valid | input | 1 | Aperture access request |
| ap_write | input | 1 | Aperture access is a write |
| ap_addr | input | AP_AW | Byte address within the aperture |
| ap_wdata | input | 32 | Aperture write data |
| ap_ready | output | 1 | Block can accept an aperture access |
| ap_resp_valid | output | 1 | Response pulse |
| ap_rdata | output | 32 | Response read data |
| ap_err | output | 1 | Response is an unconfigured-window error |
| int_valid | output | 1 | Internal request valid |
| int_write | output | 1 | Internal request is a write |
| int_addr | output | 32 | Internal byte address |
| int_wdata | output | 32 | Internal write data |
| int_fid | output | 16 | Function identity of the request |
| int_port | output | PORT_W | Port identity of the request |
| int_ready | input | 1 | Internal side grants the request |
| int_rdata | input | 32 | Internal read data, valid with the grant |

## Verification
Two things can land on the same clock edge: a configuration write that retargets a window, and the acceptance of an aperture access to that same window. The bench drives both in one cycle, rewriting window 1's base while it reads through window 1's slice. The forwarded internal address must still come from the old base, and a following read must come from the new one. A stall on the internal grant is also covered: the bench holds the grant off and checks that the request stays put and that the aperture is not ready.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;
  localparam int DW = 32;
  localparam int FID_W = 16;
  localparam int PORT_W = 2;
  localparam int PF_ID_W = 4;
  // pretend word bit positions
  localparam int CTL_USE_PORT = 2;
  localparam int CTL_PRT_PORT = 3;
  localparam int CTL_CONCRETE = 4;
  localparam int CTL_PRT_FN = 5;
  localparam int FID_LSB = 16;
  localparam int FID_VF_VALID = 15;
  localparam logic [DW-1:0] OFF_INVALID = '1;
  localparam logic [DW-1:0] ERR_WORD = 32'hDEADBEEF;
  typedef enum logic {S_IDLE, S_WAIT} xl_state_e;
endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
  import win_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int WIN_IW = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WIN_IW:0]   sel,
  input  logic [DW-1:0]     wdata,
  input  logic [WIN_IW-1:0] rd_win,
  output logic [DW-1:0]     rd_off,
  output logic [DW-1:0]     rd_prt
);
  logic [DW-1:0] off_q [NUM_WIN];
  logic [DW-1:0] prt_q [NUM_WIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        off_q[i] <= OFF_INVALID;
        prt_q[i] <= '0;
      end
    end else if (we) begin
      if (sel[0]) prt_q[sel[WIN_IW:1]] <= wdata;
      else        off_q[sel[WIN_IW:1]] <= wdata;
    end
  end

  assign rd_off = off_q[rd_win];
  assign rd_prt = prt_q[rd_win];
endmodule

// File: rtl/win_ident.sv
module win_ident
  import win_xlat_pkg::*;
#(
  parameter logic [FID_W-1:0]  OWN_FID  = 16'h0003,
  parameter logic [PORT_W-1:0] OWN_PORT = 2'd1
) (
  input  logic [DW-1:0]     prt,
  output logic [FID_W-1:0]  fid,
  output logic [PORT_W-1:0] port
);
  logic             fn_on, port_on;
  logic [FID_W-1:0] fid_raw, fid_sel;
  logic             unused_ctl;

  assign unused_ctl = ^prt[FID_LSB-1:CTL_PRT_FN+1];
  assign fn_on   = prt[CTL_PRT_FN] & prt[CTL_CONCRETE];
  assign port_on = prt[CTL_PRT_PORT] & prt[CTL_USE_PORT];
  assign fid_raw = prt[FID_LSB +: FID_W];
  assign fid_sel = fid_raw[FID_VF_VALID] ? fid_raw
                                         : FID_W'(fid_raw[PF_ID_W-1:0]);
  assign fid  = fn_on   ? fid_sel : OWN_FID;
  assign port = port_on ? prt[PORT_W-1:0] : OWN_PORT;
endmodule

// File: rtl/win_xlat.sv
module win_xlat
  import win_xlat_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int WIN_BYTES = 1024,
  parameter logic [FID_W-1:0]  OWN_FID  = 16'h0003,
  parameter logic [PORT_W-1:0] OWN_PORT = 2'd1,
  localparam int WIN_IW  = $clog2(NUM_WIN),
  localparam int SLICE_W = $clog2(WIN_BYTES),
  localparam int AP_AW   = WIN_IW + SLICE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WIN_IW:0]   cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              ap_valid,
  input  logic              ap_write,
  input  logic [AP_AW-1:0]  ap_addr,
  input  logic [DW-1:0]     ap_wdata,
  output logic              ap_ready,
  output logic              ap_resp_valid,
  output logic [DW-1:0]     ap_rdata,
  output logic              ap_err,
  output logic              int_valid,
  output logic              int_write,
  output logic [DW-1:0]     int_addr,
  output logic [DW-1:0]     int_wdata,
  output logic [FID_W-1:0]  int_fid,
  output logic [PORT_W-1:0] int_port,
  input  logic              int_ready,
  input  logic [DW-1:0]     int_rdata
);
  xl_state_e         st;
  logic [WIN_IW-1:0] win;
  logic [SLICE_W-1:0] slice;
  logic [DW-1:0]     base_dw, prt_word, xaddr;
  logic [FID_W-1:0]  id_fid;
  logic [PORT_W-1:0] id_port;
  logic              win_bad;

  assign win   = ap_addr[AP_AW-1:SLICE_W];
  assign slice = ap_addr[SLICE_W-1:0];

  win_cfg_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rd_win(win), .rd_off(base_dw), .rd_prt(prt_word)
  );

  win_ident #(.OWN_FID(OWN_FID), .OWN_PORT(OWN_PORT)) u_ident (
    .prt(prt_word), .fid(id_fid), .port(id_port)
  );

  assign win_bad  = (base_dw == OFF_INVALID);
  assign xaddr    = {base_dw[DW-3:0], 2'b00} + DW'(slice);
  assign ap_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      int_valid     <= 1'b0;
      int_write     <= 1'b0;
      int_addr      <= '0;
      int_wdata     <= '0;
      int_fid       <= '0;
      int_port      <= '0;
      ap_resp_valid <= 1'b0;
      ap_rdata      <= '0;
      ap_err        <= 1'b0;
    end else begin
      ap_resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (ap_valid) begin
          if (win_bad) begin
            ap_resp_valid <= 1'b1;
            ap_err        <= 1'b1;
            ap_rdata      <= ap_write ? '0 : ERR_WORD;
          end else begin
            int_valid <= 1'b1;
            int_write <= ap_write;
            int_addr  <= xaddr;
            int_wdata <= ap_wdata;
            int_fid   <= id_fid;
            int_port  <= id_port;
            st        <= S_WAIT;
          end
        end
        S_WAIT: if (int_ready) begin
          int_valid     <= 1'b0;
          ap_resp_valid <= 1'b1;
          ap_err        <= 1'b0;
          ap_rdata      <= int_write ? '0 : int_rdata;
          st            <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/win_xlat_chk.sv
module win_xlat_chk #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ap_valid,
  input logic          ap_ready,
  input logic          ap_write,
  input logic          ap_resp_valid,
  input logic          ap_err,
  input logic [31:0]   ap_rdata,
  input logic          int_valid,
  input logic          int_ready,
  input logic [31:0]   int_addr,
  input logic [15:0]   int_fid,
  input logic [PW-1:0] int_port
);
  // R5: error responses follow an acceptance and nothing is forwarded
  p_no_fwd_err_r5: assert property (@(posedge clk) disable iff (rst)
    ap_resp_valid && ap_err |-> !int_valid && $past(ap_valid && ap_ready));

  // R5: a read to an unconfigured window returns the error word
  p_err_word_r5: assert property (@(posedge clk) disable iff (rst)
    ap_resp_valid && ap_err && !$past(ap_write) |-> ap_rdata == 32'hDEADBEEF);

  // R4: a grant is followed by a clean response
  p_resp_after_grant_r4: assert property (@(posedge clk) disable iff (rst)
    int_valid && int_ready |=> ap_resp_valid && !ap_err);

  // R11: no new acceptance while a request is outstanding
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    int_valid |-> !ap_ready);

  // R11: a stalled request holds
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    int_valid && !int_ready |=> int_valid && $stable(int_addr)
      && $stable(int_fid) && $stable(int_port));
endmodule

bind win_xlat win_xlat_chk #(.PW(win_xlat_pkg::PORT_W)) u_chk (
  .clk(clk), .rst(rst), .ap_valid(ap_valid), .ap_ready(ap_ready),
  .ap_write(ap_write), .ap_resp_valid(ap_resp_valid), .ap_err(ap_err),
  .ap_rdata(ap_rdata), .int_valid(int_valid), .int_ready(int_ready),
  .int_addr(int_addr), .int_fid(int_fid), .int_port(int_port)
);

// File: tb/win_xlat_test.sv
`timescale 1ns/1ps
module win_xlat_test;
  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ap_valid = 0, ap_write = 0;
  logic [11:0] ap_addr = '0;
  logic [31:0] ap_wdata = '0;
  logic        ap_ready, ap_resp_valid, ap_err;
  logic [31:0] ap_rdata;
  logic        int_valid, int_write;
  logic [31:0] int_addr, int_wdata;
  logic [15:0] int_fid;
  logic [1:0]  int_port;
  logic        int_ready = 0;
  logic [31:0] int_rdata = '0;

  always #2.5 clk = ~clk;

  win_xlat uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ap_valid(ap_valid), .ap_write(ap_write), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_ready(ap_ready), .ap_resp_valid(ap_resp_valid), .ap_rdata(ap_rdata), .ap_err(ap_err),
    .int_valid(int_valid), .int_write(int_write), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_fid(int_fid), .int_port(int_port), .int_ready(int_ready), .int_rdata(int_rdata)
  );

  localparam logic [15:0] OWN_FID = 16'h0003;
  localparam logic [1:0]  OWN_PORT = 2'd1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit r_fwd, r_iwr, r_err, r_resp, r_stall_ok;
  logic [31:0] r_iaddr, r_iwd, r_rd;
  logic [15:0] r_ifid;
  logic [1:0]  r_iport;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xl(input logic [31:0] base, input logic [9:0] sl);
    return (base << 2) + {22'b0, sl};
  endfunction

  task automatic cfg_write(input logic [1:0] w, input bit word, input logic [31:0] d);
    cfg_we = 1; cfg_sel = {w, word}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                        input logic [31:0] rsp, input int stall);
    ap_valid = 1; ap_write = wr; ap_addr = a; ap_wdata = wd;
    @(negedge clk);
    ap_valid = 0; cfg_we = 0;
    r_fwd = int_valid; r_iaddr = int_addr; r_iwr = int_write; r_iwd = int_wdata;
    r_ifid = int_fid; r_iport = int_port; r_stall_ok = 1;
    if (int_valid) begin
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        if (!(int_valid && !ap_ready && int_addr == r_iaddr)) r_stall_ok = 0;
      end
      int_ready = 1; int_rdata = rsp;
      @(negedge clk);
      int_ready = 0; int_rdata = '0;
    end
    r_resp = ap_resp_valid; r_rd = ap_rdata; r_err = ap_err;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(ap_ready == 1 && int_valid == 0 && ap_resp_valid == 0, "R1 idle after reset",
        {29'b0, ap_ready, int_valid, ap_resp_valid}, 32'h4);
    access(0, 12'h810, '0, 32'h1111_1111, 0);
    chk(!r_fwd && r_resp && r_err, "R1 window unconfigured after reset",
        {29'b0, r_fwd, r_resp, r_err}, 32'h3);
    chk(r_rd == 32'hDEADBEEF, "R5 read error word", r_rd, 32'hDEADBEEF);
    access(1, 12'h004, 32'h1234_5678, '0, 0);
    chk(!r_fwd && r_resp && r_err && r_rd == 0, "R5 write to invalid window", r_rd, 0);
  endtask

  task automatic t_translate;
    cfg_write(2'd1, 1'b0, 32'h0000_4000);
    access(0, 12'h424, '0, 32'hA5A5_1234, 0);
    chk(r_fwd && !r_iwr && r_iaddr == xl(32'h0000_4000, 10'h024), "R2 translated address",
        r_iaddr, xl(32'h0000_4000, 10'h024));
    chk(r_resp && !r_err && r_rd == 32'hA5A5_1234, "R4 read data returned", r_rd, 32'hA5A5_1234);
    chk(r_ifid == OWN_FID && r_iport == OWN_PORT, "R6 own identity",
        {14'b0, r_iport, r_ifid}, {14'b0, OWN_PORT, OWN_FID});
    cfg_write(2'd3, 1'b0, 32'h0012_3455);
    access(1, 12'hFFC, 32'hCAFE_0001, 32'h7777_7777, 0);
    chk(r_fwd && r_iaddr == xl(32'h0012_3455, 10'h3FC), "R2 last word of window 3",
        r_iaddr, xl(32'h0012_3455, 10'h3FC));
    chk(r_iwr && r_iwd == 32'hCAFE_0001 && r_rd == 0 && !r_err, "R3 write forwarded",
        r_iwd, 32'hCAFE_0001);
    access(0, 12'h800, '0, '0, 0);
    chk(!r_fwd && r_err, "R5 window 2 still unconfigured", {31'b0, r_err}, 1);
  endtask

  task automatic t_pretend;
    cfg_write(2'd1, 1'b1, 32'h00A7_000E);
    access(0, 12'h400, '0, '0, 0);
    chk(r_iport == 2'd2 && r_ifid == OWN_FID, "R7 port pretend", {14'b0, r_iport, r_ifid},
        {14'b0, 2'd2, OWN_FID});
    cfg_write(2'd1, 1'b1, 32'h0000_000A);
    access(0, 12'h400, '0, '0, 0);
    chk(r_iport == OWN_PORT, "R7 use-port clear keeps own port", {30'b0, r_iport}, {30'b0, OWN_PORT});
    cfg_write(2'd1, 1'b1, 32'h00A7_000E);
    cfg_write(2'd1, 1'b1, 32'h0A57_0038);
    access(0, 12'h400, '0, '0, 0);
    chk(r_iport == OWN_PORT, "R9 function pretend undoes port pretend", {30'b0, r_iport},
        {30'b0, OWN_PORT});
    chk(r_ifid == 16'h0007, "R8 PF id only when VF-valid clear", {16'b0, r_ifid}, 32'h7);
    cfg_write(2'd1, 1'b1, 32'h8A57_0038);
    access(0, 12'h400, '0, '0, 0);
    chk(r_ifid == 16'h8A57, "R8 full id when VF-valid set", {16'b0, r_ifid}, 32'h8A57);
    cfg_write(2'd1, 1'b1, 32'h8A57_0028);
    access(0, 12'h400, '0, '0, 0);
    chk(r_ifid == OWN_FID, "R8 no is-concrete keeps own id", {16'b0, r_ifid}, {16'b0, OWN_FID});
  endtask

  task automatic t_stall;
    access(0, 12'h408, '0, 32'h0BAD_F00D, 4);
    chk(r_stall_ok, "R11 request held while stalled", {31'b0, r_stall_ok}, 1);
    chk(r_resp && r_rd == 32'h0BAD_F00D, "R11 response after stall", r_rd, 32'h0BAD_F00D);
  endtask

  task automatic t_same_cycle;
    cfg_we = 1; cfg_sel = {2'd1, 1'b0}; cfg_wdata = 32'h0000_9000;
    access(0, 12'h410, '0, '0, 0);
    chk(r_iaddr == xl(32'h0000_4000, 10'h010), "R10 same-edge write not seen",
        r_iaddr, xl(32'h0000_4000, 10'h010));
    access(0, 12'h410, '0, '0, 0);
    chk(r_iaddr == xl(32'h0000_9000, 10'h010), "R10 next access sees new base",
        r_iaddr, xl(32'h0000_9000, 10'h010));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_translate();
    t_pretend();
    t_stall();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule